// File: doc/BRIEF.md
# Per-Pin Edge and Level Interrupt Detector

This block watches a group of already-synchronized input pins and raises a sticky interrupt flag per pin when a programmed condition occurs. Each pin is set either to edge detection or to level detection. In edge detection, separate enables choose the low-to-high transition, the high-to-low transition, or both. In level detection, the same enables choose an active-high or an active-low level. The flags can be read at any time, and the single combined request is the OR of all pending flags.

Edge detection may go through a per-pin glitch filter. The filter samples the pin on a strobe and accepts a new level only when two successive samples agree. The strobe comes from a prescaler that counts either system clocks or pulses on an external tick input, with a programmable power-of-two period. Software clears flags by presenting a mask with a clear strobe. A mask bit of 1 clears that flag, and a mask bit of 0 leaves it unchanged.

Top module: `pin_irq_detect`

## Requirements
- R1: The arm word has two fields. Bit 16+i enables pin i for a rising edge or a high level. Bit i enables pin i for a falling edge or a low level. Bits 15:8 have no effect.
- R2: The per-pin mode bit selects edge detection when it is 0 and level detection when it is 1.
- R3: In edge mode, an enabled transition sets the pin's flag on the first clock edge that sees the new pin value. A transition in a direction that is not enabled sets nothing.
- R4: In level mode, the flag is set on every clock edge where the pin is at the enabled level (high with the rising enable, low with the falling enable).
- R5: In level mode, a pin with both enables set never raises its flag.
- R6: With the filter enabled in edge mode, a level change counts only after two consecutive samples have seen it. A pulse shorter than one sample period raises no flag.
- R7: The filter enable has no effect on a pin in level mode.
- R8: The sample strobe occurs once every 2^N source pulses, where N is the 4-bit period field. The source bit selects every system clock when 0 and the external tick input when 1. With no source pulses, no sample is taken.
- R9: Flags stay set until cleared. A clear strobe clears each flag whose mask bit is 1 and leaves alone each flag whose mask bit is 0.
- R10: When a set condition and a clear for the same flag occur in the same cycle, the flag stays set.
- R11: The interrupt request is high exactly when at least one flag is set.
- R12: After reset, all flags and the interrupt request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NPINS | Synchronized pin levels |
| trigLevel | input | NPINS | Per-pin mode: 0 edge, 1 level |
| armWord | input | 16+NPINS | Enables: rising/high at [16+i], falling/low at [i] |
| dbEnable | input | NPINS | Per-pin glitch filter enable (edge mode only) |
| dbSrcSel | input | 1 | Sample source: 0 system clock, 1 external tick |
| dbPeriodSel | input | 4 | Sample period exponent N (2^N source pulses) |
| extTick | input | 1 | External tick pulse |
| clrWe | input | 1 | Clear strobe |
| clrMask | input | NPINS | Flags to clear when clrWe is 1 |
| flags | output | NPINS | Pending interrupt flags |
| irq | output | 1 | OR of all flags |

## Verification
The bench toggles pins singly under each enable combination. This separates a correct edge direction from a wrong one and separates edge from level behaviour. Level pins are held while a clear is applied in the same cycle, which tells set-wins apart from clear-wins. A pin with both level enables is held high and then low to show that it stays silent. For the filter, a one-cycle glitch is compared with a long hold, and the external-tick source is tried first with no ticks and then with a few. Together these show that filtering, rather than raw edge detection, decides the outcome.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int PERIOD_SEL_W = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleStb;  // filter sampling instant
    logic clearStb;   // apply clear mask this cycle
  } irqCtrl_t;
endpackage

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int SEL_W = PERIOD_SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extTick,
  input  logic             dbSrcSel,
  input  logic [SEL_W-1:0] dbPeriodSel,
  input  logic             clrWe,
  output irqCtrl_t         ctrlStb
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] tickLimit;
  logic             srcPulse;
  logic             sampleStb;

  assign srcPulse  = dbSrcSel ? extTick : 1'b1;
  assign tickLimit = (CNT_W'(1) << dbPeriodSel) - CNT_W'(1);
  assign sampleStb = srcPulse && (tickCnt >= tickLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (srcPulse) begin
      tickCnt <= sampleStb ? '0 : tickCnt + CNT_W'(1);
    end
  end

  assign ctrlStb.sampleStb = sampleStb;
  assign ctrlStb.clearStb  = clrWe;

  AST_EXT_GATES_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    dbSrcSel && !extTick |-> !sampleStb) else $error("sample without tick"); // R8

  AST_PERIOD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !sampleStb || dbPeriodSel == '0) else $error("back-to-back samples"); // R8
endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] trigLevel,
  input  logic [NPINS-1:0] enRise,
  input  logic [NPINS-1:0] enFall,
  input  logic [NPINS-1:0] dbEnable,
  input  logic [NPINS-1:0] clrMask,
  input  irqCtrl_t         ctrlStb,
  output logic [NPINS-1:0] flagQ
);
  logic [NPINS-1:0] rawPrev;
  logic [NPINS-1:0] smpPrev;
  logic [NPINS-1:0] dbLevel;
  logic [NPINS-1:0] dbPrev;
  logic [NPINS-1:0] sampleAgree;
  logic [NPINS-1:0] edgeHit;
  logic [NPINS-1:0] levelHit;
  logic [NPINS-1:0] setEv;
  logic [NPINS-1:0] clrVec;

  assign sampleAgree = ~(pinIn ^ smpPrev);
  assign clrVec      = ctrlStb.clearStb ? clrMask : '0;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic nowLvl;
    logic oldLvl;
    // Filtered or raw view of the pin for edge detection
    assign nowLvl = dbEnable[i] ? dbLevel[i] : pinIn[i];
    assign oldLvl = dbEnable[i] ? dbPrev[i]  : rawPrev[i];
    assign edgeHit[i]  = (enRise[i] & nowLvl & ~oldLvl) | (enFall[i] & ~nowLvl & oldLvl);
    // Level detection: exactly one enable allowed
    assign levelHit[i] = (enRise[i] ^ enFall[i]) & (enRise[i] ? pinIn[i] : ~pinIn[i]);
    assign setEv[i]    = trigLevel[i] ? levelHit[i] : edgeHit[i];

    AST_NO_ARM_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      !flagQ[i] && !enRise[i] && !enFall[i] |=> !flagQ[i]) else $error("flag without enable"); // R1
    AST_BOTH_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !flagQ[i] && trigLevel[i] && enRise[i] && enFall[i] |=> !flagQ[i]) else $error("both-level fired"); // R5
    AST_LEVEL_HIGH_SETS: assert property (@(posedge clk) disable iff (!rstN)
      trigLevel[i] && enRise[i] && !enFall[i] && pinIn[i] |=> flagQ[i]) else $error("level high missed"); // R4
    AST_WRITE0_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
      flagQ[i] && !(ctrlStb.clearStb && clrMask[i]) |=> flagQ[i]) else $error("flag lost"); // R9
    AST_FILTER_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
      !ctrlStb.sampleStb |=> $stable(dbLevel[i])) else $error("filter moved off-sample"); // R6
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawPrev <= '0;
      smpPrev <= '0;
      dbLevel <= '0;
      dbPrev  <= '0;
      flagQ   <= '0;
    end else begin
      rawPrev <= pinIn;
      dbPrev  <= dbLevel;
      if (ctrlStb.sampleStb) begin
        smpPrev <= pinIn;
        dbLevel <= (dbLevel & ~sampleAgree) | (pinIn & sampleAgree);
      end
      flagQ <= (flagQ & ~clrVec) | setEv;  // set has priority
    end
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NPINS-1:0]        pinIn,
  input  logic [NPINS-1:0]        trigLevel,
  input  logic [16+NPINS-1:0]     armWord,
  input  logic [NPINS-1:0]        dbEnable,
  input  logic                    dbSrcSel,
  input  logic [PERIOD_SEL_W-1:0] dbPeriodSel,
  input  logic                    extTick,
  input  logic                    clrWe,
  input  logic [NPINS-1:0]        clrMask,
  output logic [NPINS-1:0]        flags,
  output logic                    irq
);
  localparam int RISE_LSB = 16;
  localparam int FALL_LSB = 0;

  irqCtrl_t         ctrlStb;
  logic [NPINS-1:0] enRise;
  logic [NPINS-1:0] enFall;
  logic             armUnused;

  assign enRise    = armWord[RISE_LSB +: NPINS];
  assign enFall    = armWord[FALL_LSB +: NPINS];
  assign armUnused = ^armWord[RISE_LSB-1:FALL_LSB+NPINS];

  pin_irq_ctrl #(.SEL_W(PERIOD_SEL_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .extTick     (extTick),
    .dbSrcSel    (dbSrcSel),
    .dbPeriodSel (dbPeriodSel),
    .clrWe       (clrWe),
    .ctrlStb     (ctrlStb)
  );

  pin_irq_datapath #(.NPINS(NPINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .trigLevel (trigLevel),
    .enRise    (enRise),
    .enFall    (enFall),
    .dbEnable  (dbEnable),
    .clrMask   (clrMask),
    .ctrlStb   (ctrlStb),
    .flagQ     (flags)
  );

  assign irq = |flags;
endmodule

// File: tb/pin_irq_detect_bench.sv
module pin_irq_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  typedef struct {
    logic [NP-1:0] expFlags;
    string         tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NP-1:0] pinIn;
  logic [NP-1:0] trigLevel;
  logic [23:0]   armWord;
  logic [NP-1:0] dbEnable;
  logic          dbSrcSel;
  logic [3:0]    dbPeriodSel;
  logic          extTick;
  logic          clrWe;
  logic [NP-1:0] clrMask;
  logic [NP-1:0] flags;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_detect #(.NPINS(NP)) u_pin_irq_detect (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .trigLevel(trigLevel),
    .armWord(armWord), .dbEnable(dbEnable), .dbSrcSel(dbSrcSel),
    .dbPeriodSel(dbPeriodSel), .extTick(extTick), .clrWe(clrWe),
    .clrMask(clrMask), .flags(flags), .irq(irq)
  );

  // Monitor: compares at falling edges, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (flags !== it.expFlags) begin
          fails++;
          $display("FAIL %s flags actual=%02h expected=%02h", it.tag, flags, it.expFlags);
        end
        checks++;
        if (irq !== (|it.expFlags)) begin
          fails++;
          $display("FAIL R11 (%s) irq actual=%0b expected=%0b", it.tag, irq, |it.expFlags);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Expected value for the state after the next rising edge
  task automatic expect_flags(input logic [NP-1:0] e, input string tag);
    expItem_t it;
    @(posedge clk);
    #1;
    it.expFlags = e;
    it.tag      = tag;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic clear(input logic [NP-1:0] m);
    clrWe = 1'b1; clrMask = m;
    tick(1);
    clrWe = 1'b0; clrMask = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; pinIn = '0; trigLevel = '0; armWord = '0; dbEnable = '0;
    dbSrcSel = 1'b0; dbPeriodSel = '0; extTick = 1'b0; clrWe = 1'b0; clrMask = '0;
    tick(3);
    rstN = 1'b1;
    expect_flags(8'h00, "R12 reset state");

    // Edge mode, rising enable on pin 0 (armWord bit 16)
    armWord[16] = 1'b1;
    pinIn[0] = 1'b1;
    expect_flags(8'h01, "R3 R1 rising edge pin0");
    expect_flags(8'h01, "R9 flag sticky");
    clear(8'h01);
    expect_flags(8'h00, "R9 write-1 clears");
    pinIn[0] = 1'b0;
    expect_flags(8'h00, "R3 falling ignored without fall enable");

    // Falling enable on pin 1 (bit 1); middle bits must do nothing
    armWord[15:8] = 8'hFF;
    armWord[1] = 1'b1;
    pinIn[1] = 1'b1;
    expect_flags(8'h00, "R1 R3 rise ignored on fall-only pin");
    pinIn[1] = 1'b0;
    expect_flags(8'h02, "R3 falling edge pin1");
    clear(8'h00);
    expect_flags(8'h02, "R9 mask 0 no effect");
    clear(8'h02);
    expect_flags(8'h00, "R9 clear pin1");

    // Level high on pin 2, clear while held: set wins
    trigLevel[2] = 1'b1; armWord[18] = 1'b1;
    pinIn[2] = 1'b1;
    expect_flags(8'h04, "R2 R4 level high pin2");
    clrWe = 1'b1; clrMask = 8'h04;
    expect_flags(8'h04, "R10 set wins over clear");
    pinIn[2] = 1'b0;
    expect_flags(8'h00, "R4 cleared once level gone");
    clrWe = 1'b0; clrMask = '0;

    // Level low on pin 3
    trigLevel[3] = 1'b1; armWord[3] = 1'b1;
    expect_flags(8'h08, "R4 level low pin3");
    pinIn[3] = 1'b1;
    clear(8'h08);
    expect_flags(8'h00, "R4 level low released");

    // Both level enables on pin 4
    trigLevel[4] = 1'b1; armWord[20] = 1'b1; armWord[4] = 1'b1;
    expect_flags(8'h00, "R5 both enables, pin low");
    pinIn[4] = 1'b1;
    expect_flags(8'h00, "R5 both enables, pin high");

    // Filter enable ignored in level mode (no sample source active)
    dbSrcSel = 1'b1;
    trigLevel[5] = 1'b1; armWord[21] = 1'b1; dbEnable[5] = 1'b1;
    pinIn[5] = 1'b1;
    expect_flags(8'h20, "R7 filter ignored in level mode");
    pinIn[5] = 1'b0;
    clear(8'h20);
    expect_flags(8'h00, "R7 clear pin5");

    // Filtered edge on pin 6, period 4 clocks
    dbSrcSel = 1'b0; dbPeriodSel = 4'd2;
    armWord[22] = 1'b1; dbEnable[6] = 1'b1;
    tick(10);
    pinIn[6] = 1'b1;
    tick(1);
    pinIn[6] = 1'b0;
    tick(20);
    expect_flags(8'h00, "R6 one-cycle glitch rejected");
    pinIn[6] = 1'b1;
    tick(20);
    expect_flags(8'h40, "R6 held level accepted");

    // External tick source on pin 7
    dbSrcSel = 1'b1; dbPeriodSel = 4'd0;
    armWord[23] = 1'b1; dbEnable[7] = 1'b1;
    pinIn[7] = 1'b1;
    tick(30);
    expect_flags(8'h40, "R8 no ticks, no sample");
    for (int k = 0; k < 3; k++) begin
      extTick = 1'b1;
      tick(1);
      extTick = 1'b0;
      tick(2);
    end
    expect_flags(8'hC0, "R8 ticks drive sampling");

    clear(8'hFF);
    expect_flags(8'h00, "R11 all clear drops irq");

    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule